// File: doc/BRIEF.md
# Two-Channel Target-Time Pulse and Clock Generator

This block drives two output pins from the running time-of-day of a precision time counter. Each time value is a seconds word plus a nanoseconds word that stays below one billion. Software configures a channel with a single strobe. The strobe carries a start time, a half period and an on/off flag. The block then picks one of two modes for that channel.

The mode follows from the half period. A half period of up to 70 ms qualifies for clock mode, and so do the exact values 125 ms, 250 ms and 500 ms. In clock mode the channel runs a square wave on its own. The first edge comes at the start time, and each later edge comes one half period after the previous one. Every other half period puts the channel in target-time mode. In that mode the channel waits for the time to reach its target, toggles the pin once, latches an interrupt cause bit and then disarms itself. Software must arm the next edge by writing a new target, normally the previous target plus the period.

A half period below 8 ns is refused, and the channel stays off. Every configuration strobe first clears whatever mode the channel was in. Cause bits are sticky and are cleared by writing one to them.

Top module: `ptp_tt_gen`

## Requirements
- R1: After reset both pins are low, every cause bit is clear, `irq` is low, and neither channel is armed or in clock mode.
- R2: In target-time mode the pin toggles on the first clock edge at which the time (seconds compared first, then nanoseconds) is greater than or equal to the target. At the same edge the channel's cause bit sets and `tt_armed` drops. Channel 0 reports on cause bit 3 and channel 1 on cause bit 4, and all other cause bits stay zero.
- R3: Once a target-time channel has fired, its pin does not change again until a new configuration strobe re-arms it.
- R4: A target that is already in the past when it is loaded fires on the clock edge right after the configuration edge.
- R5: A configuration with the channel on and a half period from 8 ns to 70,000,000 ns inclusive, or exactly 125,000,000, 250,000,000 or 500,000,000 ns, selects clock mode (`clk_active` high). Any other half period of at least 8 ns selects target-time mode (`tt_armed` high). The two are never high together.
- R6: A configuration with a half period below 8 ns leaves the channel off. Its pin does not toggle, whatever the time does.
- R7: In clock mode the pin first toggles when the time reaches the start time, and then every half period after that. The nanosecond sum wraps at one billion and carries into seconds. Clock mode never sets a cause bit.
- R8: A configuration strobe clears the channel's previous mode in the same edge, and no compare fires in that edge. A strobe with the on flag low leaves the channel off with its pin holding its level.
- R9: Writing one to a cause bit through `irq_clr` clears it. If a fire and a clear of the same bit fall in one cycle, the bit stays set. `irq` is the OR of all cause bits.
- R10: The two channels are independent. Activity on one never changes the other's pin, cause bit or mode.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tod_sec | input | 32 | Current time, seconds |
| tod_ns | input | 30 | Current time, nanoseconds (below 10^9) |
| cfg_wr | input | 2 | Per-channel configuration strobe |
| cfg_on | input | 1 | Enable flag carried by the strobe |
| cfg_sec | input | 32 | Start or target time, seconds |
| cfg_ns | input | 30 | Start or target time, nanoseconds |
| cfg_half | input | 30 | Half period in nanoseconds |
| irq_clr | input | 8 | Write-one-to-clear mask for the cause bits |
| pin_out | output | 2 | Output pin levels |
| irq_cause | output | 8 | Sticky cause bits (channel 0 at bit 3, channel 1 at bit 4) |
| irq | output | 1 | OR of all cause bits |
| tt_armed | output | 2 | Channel armed in target-time mode |
| clk_active | output | 2 | Channel running in clock mode |

## Verification
Two things can land in the same cycle: a target-time fire that sets a cause bit, and a software clear of that same bit. The bench arranges this by loading a target one second ahead. It then moves the time onto the target in the very cycle that `irq_clr` carries the channel's bit. The bit must still read one afterwards, and only a later clear on its own may bring it to zero. A second overlap is a configuration strobe arriving while a compare is due. That case is judged by the rule that the strobe's edge never toggles the pin.

// File: rtl/ptp_tt_pkg.sv
package ptp_tt_pkg;

    typedef enum logic [1:0] {
        CH_OFF      = 2'd0,
        CH_TT       = 2'd1,
        CH_CLK_WAIT = 2'd2,
        CH_CLK_RUN  = 2'd3
    } ch_mode_e;

    // Half period qualifies for autonomous clock output
    function automatic logic clk_mode_ok(
        input logic [31:0] half,
        input logic [31:0] hmax,
        input logic [31:0] fix0,
        input logic [31:0] fix1,
        input logic [31:0] fix2
    );
        return (half <= hmax) || (half == fix0) || (half == fix1) || (half == fix2);
    endfunction

endpackage

// File: rtl/ptp_tt_cmp.sv
module ptp_tt_cmp #(
    parameter int SEC_W = 32,
    parameter int NS_W  = 30
) (
    input  logic [SEC_W-1:0] now_sec,
    input  logic [NS_W-1:0]  now_ns,
    input  logic [SEC_W-1:0] ref_sec,
    input  logic [NS_W-1:0]  ref_ns,
    output logic             reached
);
    logic sec_gt;
    logic sec_eq;
    logic ns_ge;

    always_comb begin
        sec_gt  = now_sec > ref_sec;
        sec_eq  = now_sec == ref_sec;
        ns_ge   = now_ns >= ref_ns;
        reached = sec_gt || (sec_eq && ns_ge);
    end
endmodule

// File: rtl/ptp_tt_step.sv
module ptp_tt_step #(
    parameter int SEC_W      = 32,
    parameter int NS_W       = 30,
    parameter int NS_PER_SEC = 1000000000
) (
    input  logic [SEC_W-1:0] in_sec,
    input  logic [NS_W-1:0]  in_ns,
    input  logic [NS_W-1:0]  add_ns,
    output logic [SEC_W-1:0] out_sec,
    output logic [NS_W-1:0]  out_ns
);
    localparam logic [NS_W:0] WRAP = (NS_W+1)'(NS_PER_SEC);

    logic [NS_W:0] sum;

    always_comb begin
        sum = {1'b0, in_ns} + {1'b0, add_ns};
        if (sum >= WRAP) begin
            out_ns  = NS_W'(sum - WRAP);
            out_sec = in_sec + SEC_W'(1);
        end else begin
            out_ns  = NS_W'(sum);
            out_sec = in_sec;
        end
    end
endmodule

// File: rtl/ptp_tt_chan.sv
module ptp_tt_chan
    import ptp_tt_pkg::*;
#(
    parameter int SEC_W        = 32,
    parameter int NS_W         = 30,
    parameter int NS_PER_SEC   = 1000000000,
    parameter int MIN_HALF     = 8,
    parameter int CLK_MAX_HALF = 70000000,
    parameter int CLK_FIX0     = 125000000,
    parameter int CLK_FIX1     = 250000000,
    parameter int CLK_FIX2     = 500000000
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [SEC_W-1:0] tod_sec,
    input  logic [NS_W-1:0]  tod_ns,
    input  logic             cfg_wr,
    input  logic             cfg_on,
    input  logic [SEC_W-1:0] cfg_sec,
    input  logic [NS_W-1:0]  cfg_ns,
    input  logic [NS_W-1:0]  cfg_half,
    output logic             fire_o,
    output logic             pin_o,
    output logic             armed_o,
    output logic             clk_on_o
);
    localparam logic [31:0] MIN_H = 32'(MIN_HALF);
    localparam logic [31:0] MAX_H = 32'(CLK_MAX_HALF);
    localparam logic [31:0] FIX_0 = 32'(CLK_FIX0);
    localparam logic [31:0] FIX_1 = 32'(CLK_FIX1);
    localparam logic [31:0] FIX_2 = 32'(CLK_FIX2);

    typedef struct packed {
        ch_mode_e         mode;
        logic [SEC_W-1:0] edge_sec;
        logic [NS_W-1:0]  edge_ns;
        logic [NS_W-1:0]  half;
        logic             pin;
    } ch_state_t;

    ch_state_t s_d, s_q;

    logic             due;
    logic [SEC_W-1:0] nxt_sec;
    logic [NS_W-1:0]  nxt_ns;
    logic             half_ok;
    logic             want_clk;
    logic             fire;

    ptp_tt_cmp #(.SEC_W(SEC_W), .NS_W(NS_W)) u_cmp (
        .now_sec (tod_sec),
        .now_ns  (tod_ns),
        .ref_sec (s_q.edge_sec),
        .ref_ns  (s_q.edge_ns),
        .reached (due)
    );

    ptp_tt_step #(.SEC_W(SEC_W), .NS_W(NS_W), .NS_PER_SEC(NS_PER_SEC)) u_step (
        .in_sec  (s_q.edge_sec),
        .in_ns   (s_q.edge_ns),
        .add_ns  (s_q.half),
        .out_sec (nxt_sec),
        .out_ns  (nxt_ns)
    );

    always_comb begin
        s_d      = s_q;
        fire     = 1'b0;
        half_ok  = 32'(cfg_half) >= MIN_H;
        want_clk = clk_mode_ok(32'(cfg_half), MAX_H, FIX_0, FIX_1, FIX_2);
        if (cfg_wr) begin
            // reconfiguration drops both modes and the pending start first
            s_d.mode = CH_OFF;
            if (cfg_on && half_ok) begin
                s_d.edge_sec = cfg_sec;
                s_d.edge_ns  = cfg_ns;
                s_d.half     = cfg_half;
                s_d.mode     = want_clk ? CH_CLK_WAIT : CH_TT;
            end
        end else begin
            unique case (s_q.mode)
                CH_TT: begin
                    if (due) begin
                        s_d.pin  = ~s_q.pin;
                        s_d.mode = CH_OFF;
                        fire     = 1'b1;
                    end
                end
                CH_CLK_WAIT, CH_CLK_RUN: begin
                    if (due) begin
                        s_d.pin      = ~s_q.pin;
                        s_d.edge_sec = nxt_sec;
                        s_d.edge_ns  = nxt_ns;
                        s_d.mode     = CH_CLK_RUN;
                    end
                end
                default: ;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            s_q <= '{mode: CH_OFF, edge_sec: '0, edge_ns: '0, half: '0, pin: 1'b0};
        end else begin
            s_q <= s_d;
        end
    end

    assign fire_o   = fire;
    assign pin_o    = s_q.pin;
    assign armed_o  = s_q.mode == CH_TT;
    assign clk_on_o = (s_q.mode == CH_CLK_WAIT) || (s_q.mode == CH_CLK_RUN);

    AST_FIRE_DISARMS: assert property (@(posedge clk) disable iff (!rst_n)
        fire_o |=> !armed_o && (pin_o != $past(pin_o))); // R3
    AST_OFF_PIN_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
        (!armed_o && !clk_on_o && !cfg_wr) |=> $stable(pin_o)); // R8
    AST_SHORT_HALF_REFUSED: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_wr && (32'(cfg_half) < MIN_H)) |=> (!armed_o && !clk_on_o)); // R6
    AST_CLK_NO_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
        clk_on_o |-> !fire_o); // R7
    AST_MODES_EXCLUSIVE: assert property (@(posedge clk) disable iff (!rst_n)
        !(armed_o && clk_on_o)); // R5
    AST_CFG_NO_TOGGLE: assert property (@(posedge clk) disable iff (!rst_n)
        cfg_wr |=> $stable(pin_o)); // R8
endmodule

// File: rtl/ptp_tt_gen.sv
module ptp_tt_gen #(
    parameter int NCH          = 2,
    parameter int SEC_W        = 32,
    parameter int NS_W         = 30,
    parameter int CAUSE_W      = 8,
    parameter int CAUSE_BASE   = 3,
    parameter int NS_PER_SEC   = 1000000000,
    parameter int MIN_HALF     = 8,
    parameter int CLK_MAX_HALF = 70000000,
    parameter int CLK_FIX0     = 125000000,
    parameter int CLK_FIX1     = 250000000,
    parameter int CLK_FIX2     = 500000000
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [SEC_W-1:0]   tod_sec,
    input  logic [NS_W-1:0]    tod_ns,
    input  logic [NCH-1:0]     cfg_wr,
    input  logic               cfg_on,
    input  logic [SEC_W-1:0]   cfg_sec,
    input  logic [NS_W-1:0]    cfg_ns,
    input  logic [NS_W-1:0]    cfg_half,
    input  logic [CAUSE_W-1:0] irq_clr,
    output logic [NCH-1:0]     pin_out,
    output logic [CAUSE_W-1:0] irq_cause,
    output logic               irq,
    output logic [NCH-1:0]     tt_armed,
    output logic [NCH-1:0]     clk_active
);
    localparam logic [CAUSE_W-1:0] CH_BITS    = CAUSE_W'((1 << NCH) - 1);
    localparam logic [CAUSE_W-1:0] CAUSE_MASK = CH_BITS << CAUSE_BASE;

    typedef struct packed {
        logic [CAUSE_W-1:0] cause;
    } top_state_t;

    top_state_t t_d, t_q;

    logic [NCH-1:0]     fire;
    logic [CAUSE_W-1:0] fire_map;

    for (genvar g = 0; g < NCH; g++) begin : g_ch
        ptp_tt_chan #(
            .SEC_W        (SEC_W),
            .NS_W         (NS_W),
            .NS_PER_SEC   (NS_PER_SEC),
            .MIN_HALF     (MIN_HALF),
            .CLK_MAX_HALF (CLK_MAX_HALF),
            .CLK_FIX0     (CLK_FIX0),
            .CLK_FIX1     (CLK_FIX1),
            .CLK_FIX2     (CLK_FIX2)
        ) u_ch (
            .clk      (clk),
            .rst_n    (rst_n),
            .tod_sec  (tod_sec),
            .tod_ns   (tod_ns),
            .cfg_wr   (cfg_wr[g]),
            .cfg_on   (cfg_on),
            .cfg_sec  (cfg_sec),
            .cfg_ns   (cfg_ns),
            .cfg_half (cfg_half),
            .fire_o   (fire[g]),
            .pin_o    (pin_out[g]),
            .armed_o  (tt_armed[g]),
            .clk_on_o (clk_active[g])
        );

        AST_FIRE_SETS_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
            fire[g] |=> irq_cause[CAUSE_BASE+g]); // R9
    end

    always_comb begin
        fire_map = '0;
        for (int i = 0; i < NCH; i++) begin
            fire_map[CAUSE_BASE+i] = fire[i];
        end
        // a fire in the same cycle as a clear keeps the bit set
        t_d.cause = ((t_q.cause & ~irq_clr) | fire_map) & CAUSE_MASK;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            t_q <= '{cause: '0};
        end else begin
            t_q <= t_d;
        end
    end

    assign irq_cause = t_q.cause;
    assign irq       = |t_q.cause;

    initial begin
        AST_CAUSE_FITS: assert (CAUSE_BASE + NCH <= CAUSE_W); // R2
    end

    AST_CAUSE_OUTSIDE_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        (irq_cause & ~CAUSE_MASK) == '0); // R2
    AST_CLEAR_WORKS: assert property (@(posedge clk) disable iff (!rst_n)
        (irq_clr != '0 && fire == '0) |=> ((irq_cause & $past(irq_clr)) == '0)); // R9
endmodule

// File: tb/sim_ptp_tt_gen.sv
module sim_ptp_tt_gen;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [31:0] tod_sec = '0;
    logic [29:0] tod_ns = '0;
    logic [1:0]  cfg_wr = '0;
    logic        cfg_on = 1'b0;
    logic [31:0] cfg_sec = '0;
    logic [29:0] cfg_ns = '0;
    logic [29:0] cfg_half = '0;
    logic [7:0]  irq_clr = '0;
    logic [1:0]  pin_out;
    logic [7:0]  irq_cause;
    logic        irq;
    logic [1:0]  tt_armed;
    logic [1:0]  clk_active;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #4 clk = ~clk;

    ptp_tt_gen u0 (
        .clk(clk), .rst_n(rst_n), .tod_sec(tod_sec), .tod_ns(tod_ns),
        .cfg_wr(cfg_wr), .cfg_on(cfg_on), .cfg_sec(cfg_sec), .cfg_ns(cfg_ns),
        .cfg_half(cfg_half), .irq_clr(irq_clr), .pin_out(pin_out),
        .irq_cause(irq_cause), .irq(irq), .tt_armed(tt_armed), .clk_active(clk_active)
    );

    task automatic chk(input string req, input string what, input longint act, input longint exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    task automatic step();
        @(posedge clk);
        #1;
    endtask

    task automatic set_tod(input logic [31:0] s, input logic [29:0] n);
        tod_sec = s;
        tod_ns  = n;
    endtask

    task automatic cfg(input int ch, input logic on, input logic [31:0] s,
                       input logic [29:0] n, input logic [29:0] h);
        cfg_on   = on;
        cfg_sec  = s;
        cfg_ns   = n;
        cfg_half = h;
        cfg_wr   = 2'b00;
        cfg_wr[ch] = 1'b1;
        step();
        cfg_wr = 2'b00;
    endtask

    task automatic t_reset();
        chk("R1", "pins", pin_out, 0);
        chk("R1", "cause", irq_cause, 0);
        chk("R1", "irq", irq, 0);
        chk("R1", "armed", tt_armed, 0);
        chk("R1", "clk", clk_active, 0);
    endtask

    task automatic t_tt_basic();
        set_tod(10, 500);
        cfg(0, 1, 10, 1000, 100000000);
        chk("R5", "ch0 armed fallback", tt_armed[0], 1);
        chk("R5", "ch0 not clk", clk_active[0], 0);
        set_tod(10, 999);
        step();
        chk("R2", "pin0 before target", pin_out[0], 0);
        set_tod(10, 1000);
        step();
        chk("R2", "pin0 at target", pin_out[0], 1);
        chk("R2", "cause bit3", irq_cause, 8);
        chk("R2", "disarmed", tt_armed[0], 0);
        chk("R9", "irq", irq, 1);
        chk("R10", "pin1 untouched", pin_out[1], 0);
        set_tod(10, 5000);
        step();
        step();
        chk("R3", "pin0 holds after fire", pin_out[0], 1);
    endtask

    task automatic t_rearm();
        cfg(0, 1, 11, 0, 100000000);
        chk("R3", "re-armed", tt_armed[0], 1);
        set_tod(10, 999999999);
        step();
        chk("R2", "seconds compare no fire", pin_out[0], 1);
        set_tod(11, 0);
        step();
        chk("R2", "fire on seconds", pin_out[0], 0);
        chk("R2", "disarmed again", tt_armed[0], 0);
    endtask

    task automatic t_past();
        set_tod(50, 0);
        cfg(1, 1, 5, 0, 100000000);
        chk("R4", "armed after cfg edge", tt_armed[1], 1);
        chk("R8", "no toggle in cfg edge", pin_out[1], 0);
        step();
        chk("R4", "past target fires", pin_out[1], 1);
        chk("R2", "cause bit4", irq_cause[4], 1);
        chk("R10", "pin0 untouched", pin_out[0], 0);
    endtask

    task automatic t_collide();
        irq_clr = 8'h18;
        step();
        irq_clr = 8'h00;
        chk("R9", "cleared both", irq_cause, 0);
        chk("R9", "irq low", irq, 0);
        set_tod(19, 0);
        cfg(0, 1, 20, 0, 100000000);
        set_tod(20, 0);
        irq_clr = 8'h08;
        step();
        irq_clr = 8'h00;
        chk("R9", "set wins over clear", irq_cause, 8);
        chk("R2", "pin0 toggled", pin_out[0], 1);
        irq_clr = 8'h08;
        step();
        irq_clr = 8'h00;
        chk("R9", "clear alone", irq_cause, 0);
    endtask

    task automatic t_clock();
        set_tod(29, 0);
        cfg(1, 1, 30, 0, 100);
        chk("R5", "ch1 clk mode", clk_active[1], 1);
        chk("R5", "ch1 not armed", tt_armed[1], 0);
        set_tod(29, 999999999);
        step();
        chk("R7", "before start", pin_out[1], 1);
        set_tod(30, 0);
        step();
        chk("R7", "toggle at start", pin_out[1], 0);
        set_tod(30, 99);
        step();
        chk("R7", "no toggle inside half", pin_out[1], 0);
        set_tod(30, 100);
        step();
        chk("R7", "toggle after half", pin_out[1], 1);
        set_tod(30, 200);
        step();
        chk("R7", "toggle second half", pin_out[1], 0);
        chk("R7", "no cause in clk mode", irq_cause, 0);
    endtask

    task automatic t_rollover();
        cfg(1, 1, 40, 999999950, 100);
        set_tod(40, 999999950);
        step();
        chk("R7", "start edge", pin_out[1], 1);
        set_tod(41, 49);
        step();
        chk("R7", "before wrapped edge", pin_out[1], 1);
        set_tod(41, 50);
        step();
        chk("R7", "wrapped edge", pin_out[1], 0);
    endtask

    task automatic t_qualify();
        logic [29:0] halves [7] = '{30'd70000000, 30'd70000001, 30'd125000000,
                                    30'd250000000, 30'd500000000, 30'd500000001, 30'd8};
        logic        is_clk [7] = '{1'b1, 1'b0, 1'b1, 1'b1, 1'b1, 1'b0, 1'b1};
        for (int k = 0; k < 7; k++) begin
            cfg(0, 1, 99, 0, halves[k]);
            chk("R5", $sformatf("clk for half %0d", halves[k]), clk_active[0], is_clk[k]);
            chk("R5", $sformatf("armed for half %0d", halves[k]), tt_armed[0], !is_clk[k]);
        end
    endtask

    task automatic t_reject();
        logic p;
        p = pin_out[0];
        cfg(0, 1, 1, 0, 7);
        chk("R6", "off clk", clk_active[0], 0);
        chk("R6", "off armed", tt_armed[0], 0);
        set_tod(70, 0);
        step();
        step();
        chk("R6", "pin holds", pin_out[0], p);
        chk("R6", "no cause", irq_cause, 0);
    endtask

    task automatic t_disable();
        logic p;
        set_tod(50, 0);
        cfg(1, 1, 60, 0, 100);
        chk("R8", "clk on", clk_active[1], 1);
        p = pin_out[1];
        set_tod(60, 0);
        cfg(1, 0, 0, 0, 100);
        chk("R8", "clk cleared", clk_active[1], 0);
        chk("R8", "pin held at cfg", pin_out[1], p);
        set_tod(61, 0);
        step();
        step();
        chk("R8", "pin held later", pin_out[1], p);
    endtask

    initial begin
        repeat (3) step();
        rst_n = 1'b1;
        step();
        t_reset();
        t_tt_basic();
        t_rearm();
        t_past();
        t_collide();
        t_clock();
        t_rollover();
        t_qualify();
        t_reject();
        t_disable();
        done = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog actual=hung expected=finished");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end
endmodule